// File: doc/BRIEF.md
# Byte-Wide Configuration Port Loader

This block moves a configuration image from a host byte stream into the byte-parallel slave configuration port of a programmable device. When started, it drives the active-low program request for a fixed number of cycles. It then waits for the device to release its active-low init line. After that it moves the image across one byte per write strobe, with chip-select and the read/write direction line held at their write setting.

The image may begin with a file header that the target must never see. The number of header bytes is given when the block is started. Those bytes are taken from the host and dropped. Each payload byte can go out unchanged, or with its bit order reversed, to suit image formats that disagree on bit ordering.

The host marks the final payload byte. The block then watches the device's done line and ends in one of two states: complete, or error. It also ends in error if init or done fails to rise within a timeout. The init and done inputs are synchronised inside the block before use.

Top module: `cfg_port_loader`

## Requirements
- R1: A `start` pulse in the idle, complete or error state drives `prog_n` low for exactly PROG_CYCLES consecutive clock cycles. `start` has no effect in any other state.
- R2: From `start` until the synchronised `init_n_in` has been seen high after the program pulse, `s_ready` stays low and no write strobe is issued. `s_ready` is also low in the idle, complete and error states.
- R3: Every payload byte accepted from the host (`s_valid` and `s_ready` high at a clock edge) produces exactly one `wr_strobe` pulse in the following cycle, with the byte on `d_out`. While that strobe is high, `cs_n` is 0 and `rdwr_n` is 0 (0 selects a write).
- R4: The first `hdr_len` bytes accepted after init release are discarded and produce no strobe. When `hdr_len` is 0, the first accepted byte is already payload.
- R5: With `mirror_en` = 1, `d_out` bit i equals bit 7-i of the accepted byte. With `mirror_en` = 0, the byte passes unchanged. `hdr_len` and `mirror_en` are sampled at `start`.
- R6: If init is not seen high within TIMEOUT_CYCLES cycles after the program pulse ends, the block enters error. In error, `error` = 1, `s_ready` = 0 and no strobes are issued.
- R7: After the byte accepted with `s_last` = 1, `complete` stays 0 until the synchronised `done_in` is high and then rises. If TIMEOUT_CYCLES elapse first, `error` rises instead.
- R8: `complete` and `error` are never high together. Each holds until the next `start`, which clears it.
- R9: While `rst` is high, `prog_n`, `cs_n` and `rdwr_n` are 1, and `s_ready`, `wr_strobe`, `complete` and `error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a configuration run |
| hdr_len | input | HDR_W | Number of leading bytes to discard |
| mirror_en | input | 1 | Reverse bit order of each payload byte |
| s_valid | input | 1 | Host byte valid |
| s_data | input | 8 | Host byte |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Block accepts a host byte |
| init_n_in | input | 1 | Device init line, active low |
| done_in | input | 1 | Device done line |
| prog_n | output | 1 | Program request, active low |
| cs_n | output | 1 | Chip select, active low |
| rdwr_n | output | 1 | Direction, 0 = write |
| wr_strobe | output | 1 | One-cycle write strobe per byte |
| d_out | output | 8 | Byte driven to the device |
| complete | output | 1 | Configuration finished |
| error | output | 1 | Init or done timeout |

## Verification
The bench sends one table of bytes twice, once with bit reversal off and once with it on. The table includes palindromic patterns such as A5 and 3C, which read the same in both orders, next to asymmetric patterns such as 01, 12 and E6. Together they show whether the reversal is applied, skipped or applied in the wrong direction. One run carries a three-byte header of a value absent from the payload, so a header byte leaking to the device, or a payload byte being dropped, changes both the captured count and the first captured byte. A device model that never releases init, and a run in which done is never raised, drive the two timeout paths.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT_INIT,
        ST_SKIP,
        ST_LOAD,
        ST_WAIT_DONE,
        ST_COMPLETE,
        ST_FAIL
    } ld_state_e;

    typedef struct packed {
        logic              strobe;
        logic [BYTE_W-1:0] data;
    } port_beat_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)    cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfgl_bitorder.sv
module cfgl_bitorder #(
    parameter int unsigned W = 8
) (
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] rev;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev[i] = din[W-1-i];
    end

    assign dout = en ? rev : din;
endmodule

// File: rtl/cfg_port_loader.sv
module cfg_port_loader
    import cfgl_pkg::*;
#(
    parameter int unsigned PROG_CYCLES    = 16,
    parameter int unsigned TIMEOUT_CYCLES = 100000,
    parameter int unsigned HDR_W          = 16,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [HDR_W-1:0]  hdr_len,
    input  logic              mirror_en,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic              init_n_in,
    input  logic              done_in,
    output logic              prog_n,
    output logic              cs_n,
    output logic              rdwr_n,
    output logic              wr_strobe,
    output logic [BYTE_W-1:0] d_out,
    output logic              complete,
    output logic              error
);
    localparam int unsigned TMR_W = $clog2(max2(PROG_CYCLES, TIMEOUT_CYCLES) + 1);
    localparam logic [TMR_W-1:0] PROG_LAST = TMR_W'(PROG_CYCLES - 1);
    localparam logic [TMR_W-1:0] TO_LAST   = TMR_W'(TIMEOUT_CYCLES - 1);

    ld_state_e         st, st_nx;
    logic [HDR_W-1:0]  hdr_q, skip_cnt;
    logic              mir_q;
    port_beat_t        beat_q;
    logic              init_s, done_s;
    logic [TMR_W-1:0]  tcnt;
    logic [BYTE_W-1:0] flipped;
    logic              take, idle_like;

    cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_init_sync (
        .clk(clk), .rst(rst), .d(init_n_in), .q(init_s)
    );
    cfgl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
        .clk(clk), .rst(rst), .d(done_in), .q(done_s)
    );
    cfgl_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .clr(st_nx != st), .cnt(tcnt)
    );
    cfgl_bitorder #(.W(BYTE_W)) u_order (
        .en(mir_q), .din(s_data), .dout(flipped)
    );

    assign idle_like = (st == ST_IDLE) || (st == ST_COMPLETE) || (st == ST_FAIL);
    assign s_ready   = (st == ST_SKIP) || (st == ST_LOAD);
    assign take      = s_valid && s_ready;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE, ST_COMPLETE, ST_FAIL:
                if (start) st_nx = ST_PROG;
            ST_PROG:
                if (tcnt == PROG_LAST) st_nx = ST_WAIT_INIT;
            ST_WAIT_INIT:
                if (init_s)               st_nx = (hdr_q != '0) ? ST_SKIP : ST_LOAD;
                else if (tcnt == TO_LAST) st_nx = ST_FAIL;
            ST_SKIP:
                if (take && skip_cnt == hdr_q - 1'b1) st_nx = ST_LOAD;
            ST_LOAD:
                if (take && s_last) st_nx = ST_WAIT_DONE;
            ST_WAIT_DONE:
                if (done_s)               st_nx = ST_COMPLETE;
                else if (tcnt == TO_LAST) st_nx = ST_FAIL;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            hdr_q    <= '0;
            mir_q    <= 1'b0;
            skip_cnt <= '0;
            beat_q   <= '0;
        end else begin
            st <= st_nx;
            if (idle_like && start) begin
                hdr_q <= hdr_len;
                mir_q <= mirror_en;
            end
            if (st != ST_SKIP) skip_cnt <= '0;
            else if (take)     skip_cnt <= skip_cnt + 1'b1;
            beat_q.strobe <= take && (st == ST_LOAD);
            if (take && st == ST_LOAD) beat_q.data <= flipped;
        end
    end

    assign prog_n    = (st != ST_PROG);
    assign cs_n      = !((st == ST_LOAD) || beat_q.strobe);
    assign rdwr_n    = cs_n;
    assign wr_strobe = beat_q.strobe;
    assign d_out     = beat_q.data;
    assign complete  = (st == ST_COMPLETE);
    assign error     = (st == ST_FAIL);
endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk #(
    parameter int unsigned PROG_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic prog_n,
    input logic cs_n,
    input logic rdwr_n,
    input logic wr_strobe,
    input logic s_ready,
    input logic complete,
    input logic error
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (rst)          low_cnt <= 0;
        else if (!prog_n) low_cnt <= low_cnt + 1;
        else              low_cnt <= 0;
    end

    // R1
    prog_width_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_n && low_cnt != 0) |-> (low_cnt == PROG_CYCLES));

    // R2
    no_ready_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> prog_n);

    // R2
    no_strobe_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> prog_n);

    // R3
    strobe_selected_chk: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (!cs_n && !rdwr_n));

    // R6
    error_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        error |-> (!s_ready && !wr_strobe && cs_n));

    // R8
    complete_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        complete |-> (!error && !s_ready && prog_n));
endmodule

bind cfg_port_loader cfgl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_cfgl_chk (
    .clk(clk), .rst(rst), .prog_n(prog_n), .cs_n(cs_n), .rdwr_n(rdwr_n),
    .wr_strobe(wr_strobe), .s_ready(s_ready), .complete(complete), .error(error)
);

// File: tb/test_cfg_port_loader.sv
`timescale 1ns/1ps
module test_cfg_port_loader;
    localparam int PROG = 6;
    localparam int TMO  = 64;

    // stimulus byte in [15:8], its bit-reversed form in [7:0]
    localparam logic [15:0] VEC [8] = '{
        16'h0180, 16'hA5A5, 16'h0FF0, 16'h3C3C,
        16'h1248, 16'hC813, 16'h8001, 16'hE667
    };

    logic clk = 0, rst = 1, start = 0, mirror_en = 0;
    logic [15:0] hdr_len = '0;
    logic s_valid = 0, s_last = 0, s_ready;
    logic [7:0] s_data = '0;
    logic init_n_in = 1, done_in = 0;
    logic prog_n, cs_n, rdwr_n, wr_strobe, complete, error;
    logic [7:0] d_out;

    int tests = 0, fails = 0;
    int ncap = 0, bad_ready = 0, bad_strobe = 0, bad_sel = 0;
    int plow = 0, last_plow = 0, init_delay = 3, icnt = 0;
    logic [7:0] cap [32];
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_port_loader #(.PROG_CYCLES(PROG), .TIMEOUT_CYCLES(TMO), .HDR_W(16), .SYNC_STAGES(2))
    i_cfg_port_loader (
        .clk(clk), .rst(rst), .start(start), .hdr_len(hdr_len), .mirror_en(mirror_en),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .init_n_in(init_n_in), .done_in(done_in), .prog_n(prog_n), .cs_n(cs_n),
        .rdwr_n(rdwr_n), .wr_strobe(wr_strobe), .d_out(d_out),
        .complete(complete), .error(error)
    );

    // device model and port monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!prog_n) begin init_n_in = 0; icnt = 0; end
            else if (!init_n_in) begin
                if (icnt >= init_delay) init_n_in = 1;
                else icnt++;
            end
            if (s_ready && !init_n_in) bad_ready++;
            if (wr_strobe && !init_n_in) bad_strobe++;
            if (wr_strobe && (cs_n || rdwr_n)) bad_sel++;
            if (wr_strobe && ncap < 32) begin cap[ncap] = d_out; ncap++; end
            if (!prog_n) plow++;
            else if (plow != 0) begin last_plow = plow; plow = 0; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start(input int h, input bit m);
        hdr_len = 16'(h); mirror_en = m; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic send(input logic [7:0] b, input bit l);
        s_valid = 1; s_data = b; s_last = l;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 0; s_last = 0;
    endtask

    task automatic finish_done;
        @(negedge clk);
        chk(complete == 0, "R7 complete before done", complete, 0);
        done_in = 1;
        repeat (5) @(negedge clk);
        chk(complete == 1, "R7 complete after done", complete, 1);
        chk(error == 0, "R8 no error with complete", error, 0);
        done_in = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(prog_n && cs_n && rdwr_n, "R9 reset lines high", {prog_n, cs_n, rdwr_n}, 7);
        chk(!s_ready && !wr_strobe && !complete && !error, "R9 reset flags low",
            {s_ready, wr_strobe, complete, error}, 0);
        rst = 0;
        @(negedge clk);

        // R6 init never released
        init_delay = 100000;
        do_start(3, 0);
        repeat (PROG + TMO + 10) @(negedge clk);
        chk(error == 1, "R6 init timeout error", error, 1);
        chk(complete == 0, "R8 exclusive on init timeout", complete, 0);
        chk(s_ready == 0, "R6 ready low in error", s_ready, 0);
        chk(ncap == 0, "R6 no strobe on timeout", ncap, 0);
        chk(last_plow == PROG, "R1 program pulse width", last_plow, PROG);
        repeat (10) @(negedge clk);
        chk(error == 1, "R8 error holds", error, 1);

        // header skip, straight order (pass into cap[0..7])
        init_delay = 3;
        do_start(3, 0);
        chk(prog_n == 0 && error == 0, "R8 start clears error", {prog_n, error}, 0);
        for (int i = 0; i < 3; i++) send(8'h5A, 0);
        for (int i = 0; i < 8; i++) send(VEC[i][15:8], i == 7);
        finish_done();
        chk(ncap == 8, "R4 header bytes not strobed", ncap, 8);
        chk(cap[0] == VEC[0][15:8], "R4 first strobed byte is payload", cap[0], VEC[0][15:8]);

        // no header, mirrored (pass into cap[8..15])
        do_start(0, 1);
        for (int i = 0; i < 8; i++) send(VEC[i][15:8], i == 7);
        finish_done();
        chk(ncap == 16, "R4 zero header count", ncap, 16);

        for (int i = 0; i < 8; i++) begin
            chk(cap[i] == VEC[i][15:8], "R3 straight byte", cap[i], VEC[i][15:8]);
            chk(cap[8+i] == VEC[i][7:0], "R5 mirrored byte", cap[8+i], VEC[i][7:0]);
        end

        // done never arrives
        do_start(0, 0);
        send(8'h11, 0);
        send(8'h22, 1);
        repeat (TMO + 10) @(negedge clk);
        chk(error == 1, "R7 done timeout error", error, 1);
        chk(complete == 0, "R8 exclusive on done timeout", complete, 0);
        chk(cap[16] == 8'h11 && cap[17] == 8'h22, "R3 short run bytes", {cap[16], cap[17]}, 16'h1122);

        chk(bad_ready == 0, "R2 ready before init release", bad_ready, 0);
        chk(bad_strobe == 0, "R2 strobe before init release", bad_strobe, 0);
        chk(bad_sel == 0, "R3 select and write level at strobe", bad_sel, 0);
        chk(last_plow == PROG, "R1 final pulse width", last_plow, PROG);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule